// File: doc/BRIEF.md
# Depth-Cascade Match Arbiter

This block is the per-device arbitration slice of a depth-cascaded search system. Up to eight search devices share one result index bus, one set of external memory enables, one host feedback path and one wired-OR multi-match line. Devices are ranked by where they sit in a priority chain. No central arbiter decides who owns the shared lines. Each device makes that decision for itself from its own lookup outcome, the match wires of every device ranked above it, and three static straps: device address, last-device role and last-memory role.

In each cycle the array beside the slice presents a local hit, a local multi-hit flag and a local entry index, qualified by an operation strobe. The slice raises its match output combinationally in that same cycle, so the chain adds no latency. One clock later, registered enables state which device drives the index bus, the feedback pair, the memory enables and the multi-match pull-down. The index bus is parked by the last-memory device whenever no device hit, so the bus never floats.

Top module: `casc_match_arb`

## Requirements
- R1: `match_out` is high in the same cycle exactly when `op_valid` and `loc_hit` are both high.
- R2: After a cycle with `op_valid` high and any bit of `up_match` high, `idx_oe` is low in the next cycle, whether or not the device hit locally.
- R3: After a cycle with `op_valid`, `loc_hit` and no `up_match` bit set, the next cycle has `idx_oe` high and `idx_bus` equal to `{dev_addr, loc_index}`, with the device address in the upper bits.
- R4: `mm_pull` is high in the cycle after an operation where the device hit and either `loc_multi` was high or an upstream match was seen; otherwise it is low. ORed across the chain, it flags two or more hits in one device or hits in more than one device.
- R5: `fb_oe` is high only on a device strapped with `is_last_dev`, and only in the cycle after `op_valid`. In that cycle `host_valid` is 1, and `host_ack` is 1 when the device or any upstream device hit.
- R6: When an operation misses in every device, the last device reports `host_ack` 0 with `host_valid` 1. The last-memory device drives `idx_bus` with value 0.
- R7: `ctl_oe` is high only on the device strapped with `is_last_sram`. On that device, `sram_ce` follows an operation with a hit anywhere in the chain, one cycle later. `sram_we` is `sram_ce` qualified by `op_wr`.
- R8: In a cycle after no operation, the last-memory device drives `idx_bus` to 0 with `idx_oe` high, and no other device enables the bus.
- R9: Across a correctly strapped chain, at most one device has `idx_oe` high in any cycle.
- R10: While `rst` is high, every registered output (`idx_oe`, `idx_bus`, `mm_pull`, `fb_oe`, `host_ack`, `host_valid`, `ctl_oe`, `sram_ce`, `sram_we`) is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A lookup or write result from the local array is present this cycle |
| op_wr | input | 1 | The current operation also writes the external memory (write or learn) |
| loc_hit | input | 1 | Local array found a matching entry |
| loc_multi | input | 1 | Local array found more than one matching entry |
| loc_index | input | LOC_IDX_W (15) | Highest-priority local matching entry |
| up_match | input | NUM_DEV-1 (7) | Match outputs of higher-priority devices, unused bits tied to 0 |
| dev_addr | input | $clog2(NUM_DEV) (3) | Strapped device address |
| is_last_dev | input | 1 | Strap: this device drives host feedback |
| is_last_sram | input | 1 | Strap: this device drives memory enables and parks the index bus |
| match_out | output | 1 | Local hit for lower-priority devices |
| idx_bus | output | $clog2(NUM_DEV)+LOC_IDX_W (18) | Value for the shared index bus |
| idx_oe | output | 1 | Drive enable for the shared index bus |
| mm_pull | output | 1 | Pull-down request on the wired-OR multi-match line |
| host_ack | output | 1 | Match acknowledge to the host |
| host_valid | output | 1 | Lookup-complete flag to the host |
| fb_oe | output | 1 | Drive enable for the host feedback pair |
| sram_ce | output | 1 | External memory chip / output enable |
| sram_we | output | 1 | External memory write enable |
| ctl_oe | output | 1 | Drive enable for the memory enables |

## Verification
The bound checker watches each device on every cycle. It confirms that upstream suppression removes the bus enable (R2), that a sole winner presents its address and index one cycle later (R3), that a local multi-hit always pulls the shared line (R4), that the feedback and memory-control enables stay off on devices without the matching strap (R5, R7), and that reset clears every output (R10). Only a chain of devices in the bench can show the rules that depend on all of them together. These are the single bus owner across eight devices (R9), the miss report and bus parking by the last device (R6, R8), and the wired-OR combination of multi-match across devices (R4).

// File: rtl/casc_pkg.sv
package casc_pkg;

    localparam int DEF_NUM_DEV   = 8;
    localparam int DEF_LOC_IDX_W = 15;

    // Registered control flags of one device's response stage.
    typedef struct packed {
        logic idx_oe;
        logic mm_pull;
        logic fb_oe;
        logic host_ack;
        logic host_valid;
        logic ctl_oe;
        logic sram_ce;
        logic sram_we;
    } resp_ctl_t;

    localparam resp_ctl_t RESP_IDLE = '0;

    // A device takes the result when it hit and nothing above it did.
    function automatic logic takes_result(input logic valid, input logic hit,
                                          input logic up_any);
        return valid && hit && !up_any;
    endfunction

    // The parking device covers the bus when no device holds a result.
    function automatic logic parks_bus(input logic park_role, input logic valid,
                                       input logic hit, input logic up_any);
        return park_role && (!valid || (!hit && !up_any));
    endfunction

endpackage

// File: rtl/casc_prio.sv
module casc_prio #(
    parameter int UP_W = 7
) (
    input  logic            op_valid,
    input  logic            loc_hit,
    input  logic            loc_multi,
    input  logic [UP_W-1:0] up_match,
    output logic            match_out,
    output logic            up_any,
    output logic            winner,
    output logic            mm_local
);
    import casc_pkg::*;

    logic [UP_W:0] or_chain;

    assign or_chain[0] = 1'b0;
    for (genvar k = 0; k < UP_W; k++) begin : g_or
        assign or_chain[k+1] = or_chain[k] | up_match[k];
    end

    assign up_any    = or_chain[UP_W];
    assign match_out = op_valid && loc_hit;
    assign winner    = takes_result(op_valid, loc_hit, up_any);
    assign mm_local  = op_valid && loc_hit && (loc_multi || up_any);
endmodule

// File: rtl/casc_own.sv
module casc_own #(
    parameter int DEV_AW    = 3,
    parameter int LOC_IDX_W = 15,
    localparam int IDX_W    = DEV_AW + LOC_IDX_W
) (
    input  logic                 op_valid,
    input  logic                 op_wr,
    input  logic                 loc_hit,
    input  logic                 up_any,
    input  logic                 winner,
    input  logic                 mm_local,
    input  logic [LOC_IDX_W-1:0] loc_index,
    input  logic [DEV_AW-1:0]    dev_addr,
    input  logic                 is_last_dev,
    input  logic                 is_last_sram,
    output casc_pkg::resp_ctl_t  nxt_ctl,
    output logic [IDX_W-1:0]     nxt_idx
);
    import casc_pkg::*;

    logic parking;
    logic chain_hit;

    assign parking   = parks_bus(is_last_sram, op_valid, loc_hit, up_any);
    assign chain_hit = op_valid && (loc_hit || up_any);

    always_comb begin
        nxt_ctl            = RESP_IDLE;
        nxt_ctl.idx_oe     = winner || parking;
        nxt_ctl.mm_pull    = mm_local;
        nxt_ctl.fb_oe      = is_last_dev && op_valid;
        nxt_ctl.host_valid = is_last_dev && op_valid;
        nxt_ctl.host_ack   = is_last_dev && chain_hit;
        nxt_ctl.ctl_oe     = is_last_sram;
        nxt_ctl.sram_ce    = is_last_sram && chain_hit;
        nxt_ctl.sram_we    = is_last_sram && chain_hit && op_wr;
        nxt_idx            = winner ? {dev_addr, loc_index} : '0;
    end
endmodule

// File: rtl/casc_resp_reg.sv
module casc_resp_reg #(
    parameter int IDX_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  casc_pkg::resp_ctl_t nxt_ctl,
    input  logic [IDX_W-1:0]    nxt_idx,
    output casc_pkg::resp_ctl_t cur_ctl,
    output logic [IDX_W-1:0]    cur_idx
);
    import casc_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ctl <= RESP_IDLE;
            cur_idx <= '0;
        end else begin
            cur_ctl <= nxt_ctl;
            cur_idx <= nxt_idx;
        end
    end
endmodule

// File: rtl/casc_match_arb.sv
module casc_match_arb #(
    parameter int NUM_DEV   = casc_pkg::DEF_NUM_DEV,
    parameter int LOC_IDX_W = casc_pkg::DEF_LOC_IDX_W,
    localparam int DEV_AW   = $clog2(NUM_DEV),
    localparam int UP_W     = NUM_DEV - 1,
    localparam int IDX_W    = DEV_AW + LOC_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic                 op_wr,
    input  logic                 loc_hit,
    input  logic                 loc_multi,
    input  logic [LOC_IDX_W-1:0] loc_index,
    input  logic [UP_W-1:0]      up_match,
    input  logic [DEV_AW-1:0]    dev_addr,
    input  logic                 is_last_dev,
    input  logic                 is_last_sram,
    output logic                 match_out,
    output logic [IDX_W-1:0]     idx_bus,
    output logic                 idx_oe,
    output logic                 mm_pull,
    output logic                 host_ack,
    output logic                 host_valid,
    output logic                 fb_oe,
    output logic                 sram_ce,
    output logic                 sram_we,
    output logic                 ctl_oe
);
    import casc_pkg::*;

    logic      up_any, winner, mm_local;
    resp_ctl_t nxt_ctl, cur_ctl;
    logic [IDX_W-1:0] nxt_idx;

    casc_prio #(.UP_W(UP_W)) u_prio (
        .op_valid (op_valid),
        .loc_hit  (loc_hit),
        .loc_multi(loc_multi),
        .up_match (up_match),
        .match_out(match_out),
        .up_any   (up_any),
        .winner   (winner),
        .mm_local (mm_local)
    );

    casc_own #(.DEV_AW(DEV_AW), .LOC_IDX_W(LOC_IDX_W)) u_own (
        .op_valid    (op_valid),
        .op_wr       (op_wr),
        .loc_hit     (loc_hit),
        .up_any      (up_any),
        .winner      (winner),
        .mm_local    (mm_local),
        .loc_index   (loc_index),
        .dev_addr    (dev_addr),
        .is_last_dev (is_last_dev),
        .is_last_sram(is_last_sram),
        .nxt_ctl     (nxt_ctl),
        .nxt_idx     (nxt_idx)
    );

    casc_resp_reg #(.IDX_W(IDX_W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .nxt_ctl(nxt_ctl),
        .nxt_idx(nxt_idx),
        .cur_ctl(cur_ctl),
        .cur_idx(idx_bus)
    );

    assign idx_oe     = cur_ctl.idx_oe;
    assign mm_pull    = cur_ctl.mm_pull;
    assign host_ack   = cur_ctl.host_ack;
    assign host_valid = cur_ctl.host_valid;
    assign fb_oe      = cur_ctl.fb_oe;
    assign sram_ce    = cur_ctl.sram_ce;
    assign sram_we    = cur_ctl.sram_we;
    assign ctl_oe     = cur_ctl.ctl_oe;
endmodule

// File: rtl/casc_match_arb_chk.sv
module casc_match_arb_chk #(
    parameter int UP_W      = 7,
    parameter int DEV_AW    = 3,
    parameter int LOC_IDX_W = 15,
    parameter int IDX_W     = 18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 op_valid,
    input logic                 loc_hit,
    input logic                 loc_multi,
    input logic [LOC_IDX_W-1:0] loc_index,
    input logic [UP_W-1:0]      up_match,
    input logic [DEV_AW-1:0]    dev_addr,
    input logic                 is_last_dev,
    input logic                 is_last_sram,
    input logic [IDX_W-1:0]     idx_bus,
    input logic                 idx_oe,
    input logic                 mm_pull,
    input logic                 host_ack,
    input logic                 host_valid,
    input logic                 fb_oe,
    input logic                 sram_ce,
    input logic                 sram_we,
    input logic                 ctl_oe
);
    // R2
    upstream_suppress_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (up_match != '0)) |=> !idx_oe);

    // R3
    winner_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && loc_hit && (up_match == '0))
            |=> (idx_oe && idx_bus == $past({dev_addr, loc_index})));

    // R4
    local_multi_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && loc_hit && loc_multi) |=> mm_pull);

    // R5
    feedback_role_chk: assert property (@(posedge clk) disable iff (rst)
        !is_last_dev |=> !fb_oe);

    // R5
    feedback_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fb_oe |-> host_valid);

    // R7
    sram_role_chk: assert property (@(posedge clk) disable iff (rst)
        !is_last_sram |=> (!ctl_oe && !sram_ce && !sram_we));

    // R7
    write_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> sram_ce);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!idx_oe && idx_bus == '0 && !mm_pull && !fb_oe && !host_ack
                 && !host_valid && !ctl_oe && !sram_ce && !sram_we));
endmodule

bind casc_match_arb casc_match_arb_chk #(
    .UP_W(UP_W), .DEV_AW(DEV_AW), .LOC_IDX_W(LOC_IDX_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .loc_hit(loc_hit),
    .loc_multi(loc_multi), .loc_index(loc_index), .up_match(up_match),
    .dev_addr(dev_addr), .is_last_dev(is_last_dev), .is_last_sram(is_last_sram),
    .idx_bus(idx_bus), .idx_oe(idx_oe), .mm_pull(mm_pull), .host_ack(host_ack),
    .host_valid(host_valid), .fb_oe(fb_oe), .sram_ce(sram_ce),
    .sram_we(sram_we), .ctl_oe(ctl_oe)
);

// File: tb/casc_match_arb_bench.sv
`timescale 1ns/1ps
module casc_match_arb_bench;
    localparam int ND = 8;
    localparam int LW = 15;
    localparam int AW = 3;
    localparam int IW = AW + LW;
    localparam logic [ND-1:0] LAST = 8'h80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          op, wr;
    logic [ND-1:0] hit, multi, mo;
    logic [LW-1:0] lidx [ND];
    logic [IW-1:0] ibus [ND];
    logic [ND-1:0] ioe, mm, ack, vld, fbo, ce, we, coe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    for (genvar g = 0; g < ND; g++) begin : g_dev
        logic [ND-2:0] upv;
        for (genvar j = 0; j < ND - 1; j++) begin : g_up
            assign upv[j] = (j < g) ? mo[j] : 1'b0;
        end
        casc_match_arb u_casc_match_arb (
            .clk(clk), .rst(rst), .op_valid(op), .op_wr(wr),
            .loc_hit(hit[g]), .loc_multi(multi[g]), .loc_index(lidx[g]),
            .up_match(upv), .dev_addr(AW'(g)),
            .is_last_dev(g == ND - 1), .is_last_sram(g == ND - 1),
            .match_out(mo[g]), .idx_bus(ibus[g]), .idx_oe(ioe[g]),
            .mm_pull(mm[g]), .host_ack(ack[g]), .host_valid(vld[g]),
            .fb_oe(fbo[g]), .sram_ce(ce[g]), .sram_we(we[g]), .ctl_oe(coe[g])
        );
    end

    typedef struct {
        logic [ND-1:0] oe;
        logic [IW-1:0] val;
        logic [ND-1:0] fb;
        logic          mmx, ackx, vldx, cex, wex;
        string         tag;
    } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: one operation (or idle) per cycle, expected result queued.
    task automatic step(input bit v, input bit w, input logic [ND-1:0] h,
                        input logic [ND-1:0] m, input string tag);
        exp_t e;
        int   win;
        int   nh;
        @(negedge clk);
        op = v; wr = w; hit = h; multi = m;
        for (int i = 0; i < ND; i++) lidx[i] = LW'($urandom);
        win = -1; nh = 0;
        for (int i = 0; i < ND; i++) if (v && h[i]) begin
            nh++;
            if (win < 0) win = i;
        end
        e.tag = tag;
        if (win >= 0) begin
            e.oe  = ND'(1) << win;
            e.val = {AW'(win), lidx[win]};
        end else begin
            e.oe  = LAST;
            e.val = '0;
        end
        e.mmx  = v && ((nh >= 2) || ((h & m) != '0));
        e.fb   = v ? LAST : '0;
        e.vldx = v;
        e.ackx = v && (nh > 0);
        e.cex  = v && (nh > 0);
        e.wex  = e.cex && w;
        q.push_back(e);
        #1;
        // R1: combinational match outputs in the driving cycle
        chk(mo == (v ? h : '0), {"R1 ", tag}, 32'(mo), 32'(v ? h : '0));
    endtask

    // Monitor: compares registered outputs just after each edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic [IW-1:0] bus;
            e = q.pop_front();
            bus = '0;
            for (int i = 0; i < ND; i++) if (ioe[i]) bus |= ibus[i];
            // R9: single bus owner across the chain
            chk($countones(ioe) <= 1, {"R9 ", e.tag}, 32'(ioe), 32'(e.oe));
            // R2 R3 R6 R8: owner identity and bus value
            chk(ioe == e.oe, {"R2/R3 owner ", e.tag}, 32'(ioe), 32'(e.oe));
            chk(bus == e.val, {"R3/R6/R8 value ", e.tag}, 32'(bus), 32'(e.val));
            // R4: wired-OR multi-match
            chk((|mm) == e.mmx, {"R4 ", e.tag}, 32'(mm), 32'(e.mmx));
            // R5 R6: feedback only from the last device
            chk(fbo == e.fb, {"R5 fb ", e.tag}, 32'(fbo), 32'(e.fb));
            chk((|(ack & fbo)) == e.ackx && (|(vld & fbo)) == e.vldx,
                {"R5/R6 ack ", e.tag}, {30'd0, |(ack & fbo), |(vld & fbo)},
                {30'd0, e.ackx, e.vldx});
            // R7: memory enables
            chk(coe == LAST, {"R7 ctl ", e.tag}, 32'(coe), 32'(LAST));
            chk((|(ce & coe)) == e.cex && (|(we & coe)) == e.wex,
                {"R7 ce/we ", e.tag}, {30'd0, |(ce & coe), |(we & coe)},
                {30'd0, e.cex, e.wex});
        end
    end

    initial begin
        #20000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        op = 0; wr = 0; hit = '0; multi = '0;
        for (int i = 0; i < ND; i++) lidx[i] = '0;
        @(posedge clk); #1;
        // R10: outputs cleared under reset
        chk(ioe == '0 && mm == '0 && fbo == '0 && coe == '0 && ce == '0 && we == '0
            && ack == '0 && vld == '0, "R10 reset", 32'(ioe | coe), 32'd0);
        @(posedge clk);
        @(negedge clk); rst = 0;
        step(0, 0, 8'h00, 8'h00, "idle park");                 // R8
        step(1, 0, 8'h00, 8'h00, "all miss");                  // R6
        for (int i = 0; i < ND; i++)
            step(1, 0, ND'(1) << i, 8'h00, "single hit");      // R3
        step(1, 0, 8'h09, 8'h00, "hits 0 and 3");              // R2 R4
        step(1, 0, 8'h80, 8'h00, "last only");
        step(1, 0, 8'h20, 8'h20, "local multi");               // R4
        step(1, 0, 8'hFF, 8'h00, "all hit");
        step(1, 1, 8'h44, 8'h00, "write op");                  // R7
        step(1, 1, 8'h00, 8'h00, "write miss");                // R7
        step(0, 1, 8'hFF, 8'hFF, "idle ignores inputs");       // R8
        step(1, 0, 8'h06, 8'h04, "upstream plus multi");
        for (int n = 0; n < 60; n++)
            step(($urandom % 4) != 0, $urandom % 2, ND'($urandom & $urandom),
                 ND'($urandom & $urandom & $urandom), "random");
        step(0, 0, 8'h00, 8'h00, "final idle");
        @(posedge clk); @(posedge clk); #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule